// File: doc/BRIEF.md
# Integer ALU with masked shifts

This block is the integer execution unit of a register-based virtual-machine core. Each operation comes with an opcode, two operands and a width select, which picks 32-bit or 64-bit arithmetic. The unit returns a result and a flag that reports a zero divisor. Its functions are additive and logical operations, low-half multiply, truncating divide and remainder, shifts whose amounts are masked to the operand width, and a set of narrowing and widening conversions.

Every operation is started with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. Most operations take a single cycle. Divide and remainder run on a restoring divider that handles one quotient bit per cycle and works on magnitudes, with the signs corrected at the end. While `busy` is high, the unit accepts no new work. Results in 32-bit mode are zero-extended to the 64-bit result port.

Top module: `int_exec_unit`

## Requirements
- R1: ADD (op 0) gives a+b, SUB (op 1) gives a-b, and RSUB (op 2) gives b-a, each modulo 2^width.
- R2: MUL (op 3) returns the low 32 or 64 bits of the signed product.
- R3: AND (op 6), OR (op 7), XOR (op 8) are bitwise; NEG (op 12) gives the two's-complement negation of a and NOT (op 13) gives the ones' complement of a.
- R4: SHL (op 9), arithmetic SHR (op 10) and logical USHR (op 11) shift a by the low 5 bits of b in 32-bit mode and by the low 6 bits in 64-bit mode; the other bits of b are ignored.
- R5: DIV (op 4) truncates toward zero and REM (op 5) returns a-(a/b)*b, so the remainder takes the sign of the dividend; the most negative value divided by -1 gives the most negative value with remainder 0.
- R6: DIV or REM with a zero divisor sets div_zero, returns result 0, and asserts done on the edge after the start edge; div_zero is 0 after every other operation.
- R7: SEXT8 (op 14) sign-extends a[7:0], ZEXT16 (op 15) zero-extends a[15:0], SEXT16 (op 16) sign-extends a[15:0], and TRUNC32 (op 17) keeps a[31:0], each giving a 32-bit value zero-extended to 64 bits; SEXT32 (op 18) sign-extends a[31:0] to 64 bits. None of these depends on wide.
- R8: With wide=0 only bits 31:0 of a and b are used, and result[63:32] is 0 for every operation except SEXT32.
- R9: An operation other than a nonzero divide asserts done on the edge after the start edge. A nonzero divide holds busy high and asserts done N+1 edges after the start edge, where N is 32 or 64. done lasts one cycle and is never high together with busy.
- R10: A start pulse that arrives while busy is high is ignored. The result of the running divide and its completion time do not change.
- R11: After reset, busy, done, div_zero and result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| op | input | 5 | Operation code |
| wide | input | 1 | 1 selects 64-bit, 0 selects 32-bit arithmetic |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: result and div_zero are valid |
| result | output | 64 | Operation result, held until the next accepted start |
| div_zero | output | 1 | The last divide or remainder had a zero divisor |

## Verification
Every opcode is run in both widths against the full cross product of a set of boundary operands. The set includes zero, ±1, small odd values of both signs, the most positive and most negative values, and a mixed bit pattern. Shift amounts above the width check that the masking uses the right number of bits. The cross product covers all four sign combinations of divide and remainder, the zero divisor case, and the most-negative-by-minus-one case. In 32-bit mode the upper operand halves carry varying junk, which shows whether the unit reads beyond bit 31. A start pulse injected during a division checks that the unit refuses new work while busy.

// File: rtl/int_exec_pkg.sv
`timescale 1ns/1ps
package int_exec_pkg;

    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_RSUB   = 5'd2,
        OP_MUL    = 5'd3,
        OP_DIV    = 5'd4,
        OP_REM    = 5'd5,
        OP_AND    = 5'd6,
        OP_OR     = 5'd7,
        OP_XOR    = 5'd8,
        OP_SHL    = 5'd9,
        OP_SHR    = 5'd10,
        OP_USHR   = 5'd11,
        OP_NEG    = 5'd12,
        OP_NOT    = 5'd13,
        OP_SEXT8  = 5'd14,
        OP_ZEXT16 = 5'd15,
        OP_SEXT16 = 5'd16,
        OP_TRUNC32 = 5'd17,
        OP_SEXT32 = 5'd18
    } exec_op_e;

    localparam int NUM_OPS = 19;

    function automatic logic op_is_div(exec_op_e op);
        return (op == OP_DIV) || (op == OP_REM);
    endfunction

endpackage

// File: rtl/int_alu_logic.sv
`timescale 1ns/1ps
module int_alu_logic
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  exec_op_e            op_i,
    input  logic                wide_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   res_o
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int SH_W    = $clog2(DATA_W);
    localparam int BYTE_W  = 8;
    localparam int SHORT_W = 16;

    logic [DATA_W-1:0] a_s, b_s, a_z, raw, narrow;
    logic [SH_W-1:0]   shamt;
    logic              is_narrow;

    always_comb begin
        // operands: sign- and zero-extended views of the active width
        a_s   = wide_i ? a_i : {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
        b_s   = wide_i ? b_i : {{HALF_W{b_i[HALF_W-1]}}, b_i[HALF_W-1:0]};
        a_z   = wide_i ? a_i : {{HALF_W{1'b0}}, a_i[HALF_W-1:0]};
        shamt = wide_i ? b_i[SH_W-1:0] : {1'b0, b_i[SH_W-2:0]};

        raw = '0;
        unique case (op_i)
            OP_ADD:  raw = a_s + b_s;
            OP_SUB:  raw = a_s - b_s;
            OP_RSUB: raw = b_s - a_s;
            OP_MUL:  raw = a_s * b_s;
            OP_AND:  raw = a_s & b_s;
            OP_OR:   raw = a_s | b_s;
            OP_XOR:  raw = a_s ^ b_s;
            OP_SHL:  raw = a_s << shamt;
            OP_SHR:  raw = $unsigned($signed(a_s) >>> shamt);
            OP_USHR: raw = a_z >> shamt;
            OP_NEG:  raw = -a_s;
            OP_NOT:  raw = ~a_s;
            default: raw = '0;
        endcase

        is_narrow = 1'b1;
        narrow    = '0;
        unique case (op_i)
            OP_SEXT8:   narrow = {{HALF_W{1'b0}},
                                  {(HALF_W-BYTE_W){a_i[BYTE_W-1]}}, a_i[BYTE_W-1:0]};
            OP_ZEXT16:  narrow = {{(DATA_W-SHORT_W){1'b0}}, a_i[SHORT_W-1:0]};
            OP_SEXT16:  narrow = {{HALF_W{1'b0}},
                                  {(HALF_W-SHORT_W){a_i[SHORT_W-1]}}, a_i[SHORT_W-1:0]};
            OP_TRUNC32: narrow = {{HALF_W{1'b0}}, a_i[HALF_W-1:0]};
            OP_SEXT32:  narrow = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
            default:    is_narrow = 1'b0;
        endcase

        if (is_narrow)
            res_o = narrow;
        else if (wide_i)
            res_o = raw;
        else
            res_o = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end

endmodule

// File: rtl/int_div_step.sv
`timescale 1ns/1ps
module int_div_step #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] rem_i,
    input  logic [DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0] dsr_i,
    output logic [DATA_W-1:0] rem_o,
    output logic [DATA_W-1:0] quo_o
);
    logic [DATA_W:0] trial, diff;

    always_comb begin
        // bring down the next dividend bit, try a subtraction
        trial = {rem_i, quo_i[DATA_W-1]};
        diff  = trial - {1'b0, dsr_i};
        if (!diff[DATA_W]) begin
            rem_o = diff[DATA_W-1:0];
            quo_o = {quo_i[DATA_W-2:0], 1'b1};
        end else begin
            rem_o = trial[DATA_W-1:0];
            quo_o = {quo_i[DATA_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        op,
    input  logic              wide,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              div_zero
);
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              dz;
        logic [DATA_W-1:0] result;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] dsr;
        logic              neg_q;
        logic              neg_r;
        logic              want_rem;
        logic              wide;
    } unit_st_t;

    unit_st_t st_d, st_q;

    exec_op_e          op_e;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] step_rem, step_quo;
    logic [DATA_W-1:0] a_s, b_s, mag_a, mag_b;
    logic [DATA_W-1:0] q_fix, r_fix, fin;

    assign op_e = exec_op_e'(op);

    int_alu_logic #(.DATA_W(DATA_W)) alu_i (
        .op_i   (op_e),
        .wide_i (wide),
        .a_i    (opa),
        .b_i    (opb),
        .res_o  (alu_res)
    );

    int_div_step #(.DATA_W(DATA_W)) step_i (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dsr_i (st_q.dsr),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    always_comb begin
        a_s   = wide ? opa : {{HALF_W{opa[HALF_W-1]}}, opa[HALF_W-1:0]};
        b_s   = wide ? opb : {{HALF_W{opb[HALF_W-1]}}, opb[HALF_W-1:0]};
        mag_a = a_s[DATA_W-1] ? -a_s : a_s;
        mag_b = b_s[DATA_W-1] ? -b_s : b_s;

        q_fix = st_q.neg_q ? -step_quo : step_quo;
        r_fix = st_q.neg_r ? -step_rem : step_rem;
        fin   = st_q.want_rem ? r_fix : q_fix;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (!st_q.busy && start) begin
            st_d.dz = 1'b0;
            if (op_is_div(op_e)) begin
                if (b_s == '0) begin
                    st_d.dz     = 1'b1;
                    st_d.result = '0;
                    st_d.done   = 1'b1;
                end else begin
                    st_d.busy     = 1'b1;
                    st_d.rem      = '0;
                    // narrow dividends sit in the top half so the
                    // first step sees their most significant bit
                    st_d.quo      = wide ? mag_a : {mag_a[HALF_W-1:0], {HALF_W{1'b0}}};
                    st_d.dsr      = mag_b;
                    st_d.cnt      = wide ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
                    st_d.neg_q    = a_s[DATA_W-1] ^ b_s[DATA_W-1];
                    st_d.neg_r    = a_s[DATA_W-1];
                    st_d.want_rem = (op_e == OP_REM);
                    st_d.wide     = wide;
                end
            end else begin
                st_d.result = alu_res;
                st_d.done   = 1'b1;
            end
        end else if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.quo = step_quo;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.result = st_q.wide ? fin : {{HALF_W{1'b0}}, fin[HALF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign result   = st_q.result;
    assign div_zero = st_q.dz;

endmodule

// File: rtl/int_exec_unit_chk.sv
`timescale 1ns/1ps
module int_exec_unit_chk
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [4:0]        op,
    input logic              wide,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              div_zero
);
    localparam int HALF_W = DATA_W / 2;

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start) || $past(busy)));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    // R6
    dz_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_zero) |-> (done && !$past(busy)));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(start) && !$past(busy) && !$past(wide)
         && ($past(op) != 5'(OP_SEXT32)))
        |-> (result[DATA_W-1:HALF_W] == '0));

endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .wide     (wide),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .div_zero (div_zero)
);

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;
    import int_exec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  op = '0;
    logic        wide = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        busy, done, div_zero;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    int_exec_unit #(.DATA_W(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .result(result), .div_zero(div_zero)
    );

    function automatic string req_of(exec_op_e o);
        case (o)
            OP_ADD, OP_SUB, OP_RSUB:                 return "R1";
            OP_MUL:                                  return "R2";
            OP_AND, OP_OR, OP_XOR, OP_NEG, OP_NOT:   return "R3";
            OP_SHL, OP_SHR, OP_USHR:                 return "R4";
            OP_DIV, OP_REM:                          return "R5";
            default:                                 return "R7";
        endcase
    endfunction

    // {div_zero, result}, computed from the requirements
    function automatic logic [64:0] model(exec_op_e o, bit w, logic [63:0] a, logic [63:0] b);
        logic signed [63:0] as_, bs_, q, r;
        logic [63:0] az, res;
        int sh;
        bit dz;
        as_ = w ? a : {{32{a[31]}}, a[31:0]};
        bs_ = w ? b : {{32{b[31]}}, b[31:0]};
        az  = w ? a : {32'h0, a[31:0]};
        sh  = w ? int'(b[5:0]) : int'(b[4:0]);
        dz  = 0;
        res = '0;
        case (o)
            OP_ADD:  res = as_ + bs_;
            OP_SUB:  res = as_ - bs_;
            OP_RSUB: res = bs_ - as_;
            OP_MUL:  res = as_ * bs_;
            OP_AND:  res = as_ & bs_;
            OP_OR:   res = as_ | bs_;
            OP_XOR:  res = as_ ^ bs_;
            OP_SHL:  res = as_ << sh;
            OP_SHR:  res = as_ >>> sh;
            OP_USHR: res = az >> sh;
            OP_NEG:  res = -as_;
            OP_NOT:  res = ~as_;
            OP_DIV, OP_REM: begin
                if (bs_ == 0) begin
                    dz = 1;
                    res = '0;
                end else begin
                    if (as_ == 64'sh8000_0000_0000_0000 && bs_ == -64'sd1)
                        q = as_;
                    else
                        q = as_ / bs_;
                    r = as_ - q * bs_;
                    res = (o == OP_DIV) ? q : r;
                end
            end
            default: ;
        endcase
        if (!w) res = {32'h0, res[31:0]};
        case (o)
            OP_SEXT8:   res = {32'h0, {24{a[7]}}, a[7:0]};
            OP_ZEXT16:  res = {48'h0, a[15:0]};
            OP_SEXT16:  res = {32'h0, {16{a[15]}}, a[15:0]};
            OP_TRUNC32: res = {32'h0, a[31:0]};
            OP_SEXT32:  res = {{32{a[31]}}, a[31:0]};
            default: ;
        endcase
        return {dz, res};
    endfunction

    task automatic check(string tag, string what, logic [64:0] got, logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got dz=%0b res=%h, expected dz=%0b res=%h",
                     tag, what, got[64], got[63:0], exp[64], exp[63:0]);
        end
    endtask

    task automatic run_op(exec_op_e o, bit w, logic [63:0] a, logic [63:0] b);
        logic [64:0] exp;
        int lat, exp_lat;
        bit saw_busy;
        exp = model(o, w, a, b);
        exp_lat = (op_is_div(o) && !exp[64]) ? (w ? 65 : 33) : 1;
        @(negedge clk);
        op = o; wide = w; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        saw_busy = busy;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(req_of(o), $sformatf("op=%0d w=%0d a=%h b=%h", o, w, a, b),
              {div_zero, result}, exp);
        // R9 completion time and busy indication
        check("R9", $sformatf("latency op=%0d w=%0d", o, w),
              {32'h0, 1'b0, saw_busy, lat[30:0]},
              {32'h0, 1'b0, (exp_lat > 1), exp_lat[30:0]});
        if (op_is_div(o) && (exp[64] || b == 0))
            check("R6", "zero-divisor flag", {64'h0, div_zero}, {64'h0, exp[64]});
    endtask

    logic [31:0] v32 [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h2, 32'h7,
                              32'hFFFF_FFF9, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'h1234_5678, 32'h0000_0025};
    logic [63:0] v64 [10] = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3,
                              64'hFFFF_FFFF_FFFF_FFF9, 64'h7FFF_FFFF_FFFF_FFFF,
                              64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF,
                              64'h0000_0000_0000_0047, 64'hFFFF_FFFF_0000_0000};

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "reset state", {div_zero, result}, 65'h0);
        check("R11", "reset handshake", {63'h0, busy, done}, 65'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: 32-bit sweep with junk in the upper operand halves
        for (int k = 0; k < NUM_OPS; k++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(exec_op_e'(k), 1'b0,
                           {32'hA5C3_0000 ^ 32'(i * 7919), v32[i]},
                           {32'h5A3C_0000 ^ 32'(j * 104729), v32[j]});

        for (int k = 0; k < NUM_OPS; k++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(exec_op_e'(k), 1'b1, v64[i], v64[j]);

        // R10: a start during a division is ignored
        begin
            int lat;
            @(negedge clk);
            op = OP_DIV; wide = 1'b0; opa = 64'd100; opb = 64'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 1;
            repeat (4) begin @(negedge clk); lat++; end
            op = OP_ADD; opa = 64'd1; opb = 64'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
            while (!done && lat < 200) begin @(negedge clk); lat++; end
            check("R10", "divide result after ignored start", {div_zero, result}, {1'b0, 64'd14});
            check("R10", "divide latency after ignored start", 65'(lat), 65'd33);
            @(negedge clk);
            check("R10", "no second completion", {64'h0, done}, 65'h0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule